// File: doc/BRIEF.md
# Microcoded Instruction Step Sequencer

This block drives the control plane of a small microcoded 8-bit processor. Every instruction is one byte wide. The byte is captured from the data bus into an opcode register when the load strobe is high. The strobe is itself one of the control outputs, and the surrounding logic wires it back to the `ir_load` input. A 4-bit step counter is built from chained toggle stages. It selects the micro-step of the current instruction. For each opcode and step, the block emits a 29-bit control word that drives the register load enables, the bus output enables and the ALU selects of the datapath.

Every instruction begins with the same two steps. Step 0 puts the instruction pointer on the address bus, drives memory onto the data bus and loads the opcode register. Step 1 increments the pointer. From step 2 onward, each opcode has its own list of words, and the lists differ in length. A dedicated end bit in the word returns the counter to step 0 at the next edge. The shared fetch words and the opcode-specific words are merged as a wired-OR: a control line is high if any contributing entry asserts it.

Opcodes that have no entry execute only the fetch and end at step 1. While reset is held, the outputs stay quiet and nothing advances. The control path carries no data stream, so there is no valid/ready handshake and no back-pressure. Each word applies in the single cycle it is shown.

Top module: `ucode_step_sequencer`

## Requirements
- R1: While `rst_n` is low, `ctrl` is all zero and the step counter does not advance. After release, the opcode register and the step both read zero, so the first word shown is the step-0 fetch word.
- R2: At step 0, for any opcode, `ctrl` equals 0x103. This sets bit 0 (pointer to address bus), bit 1 (opcode register load) and bit 8 (memory to data bus).
- R3: The opcode register takes `data_bus` at a rising edge where `ir_load` is high. It keeps its value when `ir_load` is low, so bus activity in later steps does not change the running instruction.
- R4: At step 1, `ctrl` bit 2 (pointer increment) is set for every opcode.
- R5: The step advances by one each clock. After any cycle whose word has bit 3 (end of instruction) set, the next cycle is step 0.
- R6: An opcode with no table entry (for example 0x00, 0x11, 0xFF) shows exactly 0x00C at step 1 (increment plus end), and the next fetch then follows.
- R7: Contributions merge as a wired-OR. Opcode 0x40 adds bit 15 (set carry) and the end bit to the fetch's bit 2 at step 1, giving 0x0800C.
- R8: Defined opcode words for steps 2 and 3 are as follows:
  - 0x10: step 2 is 0x00518.
  - 0x30: step 2 is 0x00628.
  - 0x20: step 2 is 0x00540, then step 3 is 0x206818.
  - 0x50: step 2 is 0x00060, then step 3 is 0x182808.
  - At step 1, each of these four opcodes shows 0x004.
- R9: Opcode 0x7F runs the counter to its top value. Steps 2 to 14 are all zero, step 15 is 0x008, and the counter then returns to step 0 rather than wrapping through the table.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset; holds outputs quiet |
| data_bus | input | 8 | Shared data bus; source of the opcode byte |
| ir_load | input | 1 | Opcode register load strobe, wired back from `ctrl[1]` |
| ctrl | output | 29 | Merged control word for the current opcode and step |

## Verification
The bench goes after the following corner cases:
- **Step 1 of an undefined opcode.** A design that forgot the default end would run on into step 2 with an all-zero word and never refetch.
- **The single-step-1 instruction 0x40.** A design that selected one table entry instead of merging would lose either the pointer increment or the carry set.
- **The 16-step instruction.** It exposes a toggle chain with a broken carry between stages, or a counter that wraps without the end bit.
- **Changes to the data bus in later steps.** A register that loads on every edge would switch opcodes part-way through an instruction.
- **Reset in mid-instruction.** A design that gates only the outputs would resume from a stale step.

// File: rtl/ucseq_pkg.sv
package ucseq_pkg;
  localparam int OP_W   = 8;
  localparam int STEP_W = 4;
  localparam int CTRL_W = 29;

  // control line positions
  localparam int B_IP_ADDR = 0;
  localparam int B_IR_LD   = 1;
  localparam int B_IP_INC  = 2;
  localparam int B_END     = 3;
  localparam int B_A_LD    = 4;
  localparam int B_A_OUT   = 5;
  localparam int B_B_LD    = 6;
  localparam int B_B_OUT   = 7;
  localparam int B_MEM_OUT = 8;
  localparam int B_MEM_WR  = 9;
  localparam int B_PC_ADDR = 10;
  localparam int B_ALU_ADD = 11;
  localparam int B_ALU_SUB = 12;
  localparam int B_ALU_OUT = 13;
  localparam int B_FLG_LD  = 14;
  localparam int B_CF_SET  = 15;
  localparam int B_CF_CLR  = 16;
  localparam int B_P_LD    = 17;
  localparam int B_C_LD    = 18;
  localparam int B_IP_LD   = 19;
  localparam int B_SRC_IP  = 20;
  localparam int B_SRC_A   = 21;

  typedef logic [CTRL_W-1:0] ctrl_t;

  function automatic ctrl_t bit_of(input int pos);
    ctrl_t w;
    w = '0;
    w[pos] = 1'b1;
    return w;
  endfunction
endpackage

// File: rtl/ucseq_step_counter.sv
module ucseq_step_counter #(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  output logic [WIDTH-1:0] step
);
  logic [WIDTH-1:0] tgl;

  assign tgl[0] = 1'b1;

  generate
    for (genvar i = 1; i < WIDTH; i++) begin : g_carry
      assign tgl[i] = tgl[i-1] & step[i-1];
    end
    for (genvar i = 0; i < WIDTH; i++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   step[i] <= 1'b0;
        else if (clr) step[i] <= 1'b0;
        else if (tgl[i]) step[i] <= ~step[i];
      end
    end
  endgenerate
endmodule

// File: rtl/ucseq_instr_reg.sv
module ucseq_instr_reg #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q <= '0;
    else if (load) q <= din;
  end
endmodule

// File: rtl/ucseq_op_table.sv
module ucseq_op_table
  import ucseq_pkg::*;
(
  input  logic [OP_W-1:0]   opcode,
  input  logic [STEP_W-1:0] step,
  output ctrl_t             word,
  output logic              known
);
  always_comb begin
    word  = '0;
    known = 1'b1;
    case (opcode)
      8'h10: if (step == 4'd2)
               word = bit_of(B_PC_ADDR) | bit_of(B_MEM_OUT) | bit_of(B_A_LD) | bit_of(B_END);
      8'h20: begin
        if (step == 4'd2)
          word = bit_of(B_PC_ADDR) | bit_of(B_MEM_OUT) | bit_of(B_B_LD);
        else if (step == 4'd3)
          word = bit_of(B_SRC_A) | bit_of(B_ALU_ADD) | bit_of(B_ALU_OUT)
               | bit_of(B_A_LD) | bit_of(B_FLG_LD) | bit_of(B_END);
      end
      8'h30: if (step == 4'd2)
               word = bit_of(B_PC_ADDR) | bit_of(B_A_OUT) | bit_of(B_MEM_WR) | bit_of(B_END);
      8'h40: if (step == 4'd1)
               word = bit_of(B_CF_SET) | bit_of(B_END);
      8'h50: begin
        if (step == 4'd2)
          word = bit_of(B_A_OUT) | bit_of(B_B_LD);
        else if (step == 4'd3)
          word = bit_of(B_SRC_IP) | bit_of(B_ALU_ADD) | bit_of(B_ALU_OUT)
               | bit_of(B_IP_LD) | bit_of(B_END);
      end
      8'h7F: if (step == 4'd15)
               word = bit_of(B_END);
      default: known = 1'b0;
    endcase
  end
endmodule

// File: rtl/ucode_step_sequencer.sv
module ucode_step_sequencer
  import ucseq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [OP_W-1:0]   data_bus,
  input  logic              ir_load,
  output logic [CTRL_W-1:0] ctrl
);
  logic [OP_W-1:0]   ir_q;
  logic [STEP_W-1:0] step_q;
  ctrl_t             fetch_w;
  ctrl_t             op_w;
  ctrl_t             dflt_w;
  ctrl_t             merged;
  logic              op_known;

  ucseq_instr_reg #(.WIDTH(OP_W)) u_ir (
    .clk(clk), .rst_n(rst_n), .load(ir_load), .din(data_bus), .q(ir_q)
  );

  ucseq_step_counter #(.WIDTH(STEP_W)) u_step (
    .clk(clk), .rst_n(rst_n), .clr(merged[B_END]), .step(step_q)
  );

  ucseq_op_table u_tab (
    .opcode(ir_q), .step(step_q), .word(op_w), .known(op_known)
  );

  // shared fetch contribution
  always_comb begin
    fetch_w = '0;
    if (step_q == '0)
      fetch_w = bit_of(B_IP_ADDR) | bit_of(B_MEM_OUT) | bit_of(B_IR_LD);
    else if (step_q == STEP_W'(1))
      fetch_w = bit_of(B_IP_INC);
  end

  // undefined opcodes finish after the fetch
  always_comb begin
    dflt_w = '0;
    if (!op_known && step_q == STEP_W'(1))
      dflt_w = bit_of(B_END);
  end

  assign merged = fetch_w | op_w | dflt_w;
  assign ctrl   = rst_n ? merged : '0;
endmodule

// File: rtl/ucseq_checker.sv
module ucseq_checker
  import ucseq_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              ir_load,
  input logic [OP_W-1:0]   data_bus,
  input logic [CTRL_W-1:0] ctrl,
  input logic [STEP_W-1:0] step,
  input logic [OP_W-1:0]   opcode
);
  always_comb begin
    if (!rst_n) AST_RESET_QUIET: assert (ctrl == '0); // R1
  end

  AST_FETCH_WORD: assert property (@(posedge clk) disable iff (!rst_n)
    step == '0 |-> ctrl == CTRL_W'(29'h103)); // R2

  AST_IR_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    ir_load |=> opcode == $past(data_bus)); // R3

  AST_IR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !ir_load |=> $stable(opcode)); // R3

  AST_INC_STEP1: assert property (@(posedge clk) disable iff (!rst_n)
    step == STEP_W'(1) |-> ctrl[B_IP_INC]); // R4

  AST_END_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl[B_END] |=> step == '0); // R5

  AST_STEP_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl[B_END] |=> step == $past(step) + STEP_W'(1)); // R5

  AST_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    step == '1 |-> ctrl[B_END]); // R9
endmodule

bind ucode_step_sequencer ucseq_checker u_chk (
  .clk(clk), .rst_n(rst_n), .ir_load(ir_load), .data_bus(data_bus),
  .ctrl(ctrl), .step(step_q), .opcode(ir_q)
);

// File: tb/ucode_step_sequencer_bench.sv
module ucode_step_sequencer_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  data_bus = 8'h00;
  logic        ir_load;
  logic [28:0] ctrl;
  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  assign ir_load = ctrl[1];

  ucode_step_sequencer u_ucode_step_sequencer (
    .clk(clk), .rst_n(rst_n), .data_bus(data_bus), .ir_load(ir_load), .ctrl(ctrl)
  );

  function automatic bit is_defined(input logic [7:0] op);
    return op inside {8'h10, 8'h20, 8'h30, 8'h40, 8'h50, 8'h7F};
  endfunction

  function automatic int op_len(input logic [7:0] op);
    case (op)
      8'h10, 8'h30: return 3;
      8'h20, 8'h50: return 4;
      8'h7F:        return 16;
      default:      return 2;
    endcase
  endfunction

  function automatic logic [28:0] exp_word(input logic [7:0] op, input int s);
    if (s == 0) return 29'h103;
    if (s == 1) return (op == 8'h40) ? 29'h0800C : (is_defined(op) ? 29'h004 : 29'h00C);
    case (op)
      8'h10: return 29'h00518;
      8'h30: return 29'h00628;
      8'h20: return (s == 2) ? 29'h00540 : 29'h206818;
      8'h50: return (s == 2) ? 29'h00060 : 29'h182808;
      8'h7F: return (s == 15) ? 29'h008 : 29'h000;
      default: return 29'h000;
    endcase
  endfunction

  task automatic check(input string req, input logic [28:0] act, input logic [28:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: ctrl=%h expected=%h", req, act, exp);
    end
  endtask

  // entry and exit: just after a falling edge, in step 0
  task automatic run_op(input logic [7:0] op, input string req);
    for (int s = 0; s < op_len(op); s++) begin
      if (s > 0) @(negedge clk);
      check(req, ctrl, exp_word(op, s));
      data_bus = (s == 0) ? op : ~op ^ 8'(s); // junk after fetch (R3)
    end
    @(negedge clk);
    check("R5 return to step 0", ctrl, 29'h103);
  endtask

  task automatic test_reset_start();
    #5 check("R1 quiet in reset", ctrl, 29'h0);
    @(negedge clk);
    check("R1 no advance in reset", ctrl, 29'h0);
    rst_n = 1'b1;
    #1 check("R1/R2 first word after release", ctrl, 29'h103);
  endtask

  task automatic test_undefined();
    run_op(8'h00, "R6 undefined 0x00");
    run_op(8'h11, "R6 undefined 0x11");
    run_op(8'hFF, "R6 undefined 0xFF");
  endtask

  task automatic test_defined();
    run_op(8'h10, "R8 op 0x10");
    run_op(8'h20, "R8 op 0x20");
    run_op(8'h30, "R8 op 0x30");
    run_op(8'h50, "R8 op 0x50");
    run_op(8'h40, "R7 wired-OR op 0x40");
    run_op(8'h20, "R3 R4 back-to-back 0x20");
  endtask

  task automatic test_long();
    run_op(8'h7F, "R9 sixteen-step op");
  endtask

  task automatic test_mid_reset();
    check("R2 step0", ctrl, 29'h103);
    data_bus = 8'h20;
    @(negedge clk);
    check("R4 step1 of 0x20", ctrl, 29'h004);
    @(negedge clk);
    check("R8 step2 of 0x20", ctrl, 29'h00540);
    rst_n = 1'b0;
    #1 check("R1 quiet on mid reset", ctrl, 29'h0);
    @(negedge clk);
    check("R1 held in reset", ctrl, 29'h0);
    rst_n = 1'b1;
    #1 check("R1 restart at step 0", ctrl, 29'h103);
    data_bus = 8'h00;
    @(negedge clk);
    check("R1 opcode cleared then fetched 0x00", ctrl, 29'h00C);
    @(negedge clk);
    check("R5 after mid reset", ctrl, 29'h103);
  endtask

  initial begin
    test_reset_start();
    test_undefined();
    test_defined();
    test_long();
    test_mid_reset();
    run_op(8'h40, "R7 after reset");
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: run did not complete");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule